// File: doc/BRIEF.md
# Video Transfer Unit Packer

This block takes 24-bit RGB pixels over a valid/ready handshake and turns them into one byte per symbol clock for a single link lane. A flag next to each byte says whether it is pixel data or a control symbol. Every transfer unit has the same length and layout. A fixed number of whole pixels comes first. A fill region follows, opened and closed by control symbols. Because of this, the lane runs at a constant symbol rate while the pixel rate stays below it, and a pixel is never split across two units.

With the default parameters a unit is 40 symbols long: 11 pixels (33 data bytes) and 7 fill symbols. At 270 M symbols per second this gives 74.25 M pixels per second on one lane. The lane-count parameter scales the derived effective rate to 148.5 or 297 M pixels per second on two or four lanes. The unit length is checked during elaboration against the range 32 to 64, and the fill region must be at least two symbols long.

A `line_end` pulse closes the current unit early, so the next line starts at the beginning of a fresh unit. The first byte after reset is always the first byte of a unit.

Top module: `tu_packer`

## Requirements
- R1: While `rst` is high at a clock edge, `sym_out` becomes 0 and `sym_is_ctrl` becomes 0. `pix_ready` stays low during reset. The first symbol after reset is released is position 0 of a unit.
- R2: A symbol is produced on every clock. Every unit is exactly TU_LEN (40) symbols long. Position 39 of every unit carries the fill-close control symbol 0xFC with `sym_is_ctrl` = 1. No other position carries it.
- R3: A pixel is sent over three consecutive symbols in the order bits [23:16], [15:8], [7:0], all flagged as data. Pixels leave in the order in which they were accepted.
- R4: With pixels always available and no line end, each unit carries 11 pixels at positions 0 to 32. The fill-open control symbol 0x5C (flag 1) follows at position 33. Positions 34 to 38 are zero data bytes.
- R5: `pix_ready` is high only at a pixel boundary in the data region, and only when at least three data positions remain. It is never high while a pixel is being sent or while fill is being sent.
- R6: No pixel starts after position 30. If a boundary at position 31 or 32 is reached without a pixel, those positions are sent as zero data bytes.
- R7: At a pixel boundary in the data region with `pix_valid` low, the block sends a zero data byte and the unit position still advances.
- R8: `line_end` high at a pixel boundary of the data region sends 0x5C (control) in that cycle. Zero data bytes follow up to position 38, then 0xFC at position 39. No pixel is accepted for the rest of that unit. The next unit starts taking pixels at position 0.
- R9: `line_end` high while a pixel is still being sent lets that pixel finish. The fill-open symbol is then sent at the next symbol position.
- R10: `line_end` during the fill region has no effect on the current unit or on the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | A pixel is offered on `pix_data` |
| pix_ready | output | 1 | The block takes the offered pixel at this edge |
| pix_data | input | 24 | Pixel, bits [23:16] sent first |
| line_end | input | 1 | Close the current unit at the next pixel boundary |
| sym_out | output | 8 | Registered output symbol |
| sym_is_ctrl | output | 1 | The symbol is a control code (1) or data (0) |

## Verification
The assertions assume that `line_end` is a single-cycle pulse and that it is low while reset is held. The bench pulses it once per unit, always at a chosen unit position, and keeps it low in reset. `pix_valid` may drop on any cycle without harm, so the stall patterns deliberately remove pixels at boundaries. This includes the last boundaries before the fill region, where the three-slot room rule and the zero-byte padding must agree. The bench changes every input half a cycle away from the sampling edge. The assertions therefore only ever see settled handshake values.

// File: rtl/tu_pkg.sv
package tu_pkg;

  localparam logic [7:0] SYM_FILL_OPEN  = 8'h5C;
  localparam logic [7:0] SYM_FILL_CLOSE = 8'hFC;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_FILL = 1'b1
  } phase_e;

  typedef enum logic [1:0] {
    K_ZERO  = 2'd0,
    K_PIXEL = 2'd1,
    K_OPEN  = 2'd2,
    K_CLOSE = 2'd3
  } sym_kind_e;

endpackage

// File: rtl/tu_slot_counter.sv
module tu_slot_counter #(
  parameter int TU_LEN = 40,
  parameter int POS_W  = $clog2(TU_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos,
  output logic             last
);

  assign last = (pos == POS_W'(TU_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (last) pos <= '0;
    else           pos <= pos + 1'b1;
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    last |=> (pos == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    !last |=> (pos == $past(pos) + 1'b1));

  assert_range_R2: assert property (@(posedge clk) disable iff (rst)
    pos < POS_W'(TU_LEN));

endmodule

// File: rtl/tu_pixel_serializer.sv
module tu_pixel_serializer #(
  parameter int PIX_W = 24,
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PIX_W-1:0] pix_in,
  output logic             busy,
  output logic [SYM_W-1:0] sym
);

  localparam int NSYM  = PIX_W / SYM_W;
  localparam int IDX_W = $clog2(NSYM + 1);

  logic [PIX_W-1:0] hold;
  logic [IDX_W-1:0] idx;

  assign busy = (idx != '0);
  assign sym  = load ? pix_in[PIX_W-1 -: SYM_W] : hold[PIX_W-1 -: SYM_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      idx  <= '0;
    end else if (load) begin
      hold <= pix_in << SYM_W;
      idx  <= IDX_W'(1);
    end else if (busy) begin
      hold <= hold << SYM_W;
      idx  <= (idx == IDX_W'(NSYM - 1)) ? '0 : idx + 1'b1;
    end
  end

  assert_load_boundary_R5: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);

  assert_pixel_run_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && idx != IDX_W'(NSYM - 1)) |=> busy);

  assert_start_run_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);

endmodule

// File: rtl/tu_fill_ctrl.sv
module tu_fill_ctrl
  import tu_pkg::*;
#(
  parameter int TU_LEN    = 40,
  parameter int DATA_SYMS = 33,
  parameter int NSYM      = 3,
  parameter int POS_W     = $clog2(TU_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos,
  input  logic             last,
  input  logic             busy,
  input  logic             pix_valid,
  input  logic             line_end,
  output sym_kind_e        kind,
  output logic             load,
  output logic             pix_ready
);

  phase_e phase;
  logic   pend;
  logic   room;
  logic   data_end;

  assign room     = (pos <= POS_W'(DATA_SYMS - NSYM));
  assign data_end = (pos == POS_W'(DATA_SYMS));
  assign load     = pix_ready && pix_valid;

  always_comb begin
    kind      = K_ZERO;
    pix_ready = 1'b0;
    if (phase == PH_FILL) begin
      kind = last ? K_CLOSE : K_ZERO;
    end else if (busy) begin
      kind = K_PIXEL;
    end else if (data_end || line_end || pend) begin
      kind = K_OPEN;
    end else if (room) begin
      pix_ready = !rst;
      if (pix_valid && !rst) kind = K_PIXEL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_DATA;
      pend  <= 1'b0;
    end else if (phase == PH_FILL) begin
      if (last) phase <= PH_DATA;
    end else if (kind == K_OPEN) begin
      phase <= PH_FILL;
      pend  <= 1'b0;
    end else if (busy && line_end) begin
      pend <= 1'b1;
    end
  end

  assert_fill_no_take_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FILL) |-> !pix_ready);

  assert_late_start_R6: assert property (@(posedge clk) disable iff (rst)
    load |-> (pos <= POS_W'(DATA_SYMS - NSYM)));

  assert_open_enters_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (kind == K_OPEN) |=> (phase == PH_FILL));

  assert_close_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    (kind == K_CLOSE) |-> last);

  assert_pend_in_data_R9: assert property (@(posedge clk) disable iff (rst)
    pend |-> (phase == PH_DATA));

  assert_fresh_unit_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FILL && last) |=> (phase == PH_DATA && !pend));

endmodule

// File: rtl/tu_packer.sv
module tu_packer
  import tu_pkg::*;
#(
  parameter int TU_LEN       = 40,
  parameter int PIX_PER_TU   = 11,
  parameter int PIX_W        = 24,
  parameter int SYM_W        = 8,
  parameter int LANES        = 1,
  parameter int SYM_RATE_KHZ = 270000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             line_end,
  output logic [SYM_W-1:0] sym_out,
  output logic             sym_is_ctrl
);

  localparam int NSYM        = PIX_W / SYM_W;
  localparam int DATA_SYMS   = PIX_PER_TU * NSYM;
  localparam int FILL_SYMS   = TU_LEN - DATA_SYMS;
  localparam int POS_W       = $clog2(TU_LEN);
  localparam int EFF_PIX_KHZ = (SYM_RATE_KHZ * PIX_PER_TU * LANES) / TU_LEN;

  generate
    if (TU_LEN < 32 || TU_LEN > 64) begin : g_bad_len
      $error("transfer unit length out of range 32..64");
    end
    if (FILL_SYMS < 2) begin : g_bad_fill
      $error("fill region needs at least two symbols");
    end
    if (PIX_W % SYM_W != 0 || NSYM < 2) begin : g_bad_pix
      $error("pixel width must be a multiple of at least two symbols");
    end
  endgenerate

  logic [POS_W-1:0] pos;
  logic             last;
  logic             busy;
  logic             load;
  logic [SYM_W-1:0] ser_sym;
  sym_kind_e        kind;

  tu_slot_counter #(
    .TU_LEN (TU_LEN),
    .POS_W  (POS_W)
  ) u_slots (
    .clk  (clk),
    .rst  (rst),
    .pos  (pos),
    .last (last)
  );

  tu_pixel_serializer #(
    .PIX_W (PIX_W),
    .SYM_W (SYM_W)
  ) u_ser (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .pix_in (pix_data),
    .busy   (busy),
    .sym    (ser_sym)
  );

  tu_fill_ctrl #(
    .TU_LEN    (TU_LEN),
    .DATA_SYMS (DATA_SYMS),
    .NSYM      (NSYM),
    .POS_W     (POS_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pos       (pos),
    .last      (last),
    .busy      (busy),
    .pix_valid (pix_valid),
    .line_end  (line_end),
    .kind      (kind),
    .load      (load),
    .pix_ready (pix_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_out     <= '0;
      sym_is_ctrl <= 1'b0;
    end else begin
      unique case (kind)
        K_PIXEL: begin
          sym_out     <= ser_sym;
          sym_is_ctrl <= 1'b0;
        end
        K_OPEN: begin
          sym_out     <= SYM_W'(SYM_FILL_OPEN);
          sym_is_ctrl <= 1'b1;
        end
        K_CLOSE: begin
          sym_out     <= SYM_W'(SYM_FILL_CLOSE);
          sym_is_ctrl <= 1'b1;
        end
        default: begin
          sym_out     <= '0;
          sym_is_ctrl <= 1'b0;
        end
      endcase
    end
  end

  assert_ctrl_codes_R2: assert property (@(posedge clk) disable iff (rst)
    sym_is_ctrl |-> (sym_out == SYM_W'(SYM_FILL_OPEN) ||
                     sym_out == SYM_W'(SYM_FILL_CLOSE)));

  assert_zero_slot_R7: assert property (@(posedge clk) disable iff (rst)
    (kind == K_ZERO) |=> (sym_out == '0 && !sym_is_ctrl));

  assert_ready_gated_R1: assert property (@(posedge clk)
    rst |-> !pix_ready);

  assert_rate_R4: assert property (@(posedge clk) disable iff (rst)
    EFF_PIX_KHZ <= SYM_RATE_KHZ * LANES |-> (pix_ready |-> !busy));

endmodule

// File: tb/tu_packer_tb.sv
module tu_packer_tb;

  localparam int TU = 40;
  localparam int PPT = 11;
  localparam int NS = 3;
  localparam int DS = PPT * NS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_valid = 1'b0;
  logic        line_end = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pix_ready;
  logic [7:0]  sym_out;
  logic        sym_is_ctrl;

  always #10 clk = ~clk;

  tu_packer u_dut (
    .clk         (clk),
    .rst         (rst),
    .pix_valid   (pix_valid),
    .pix_ready   (pix_ready),
    .pix_data    (pix_data),
    .line_end    (line_end),
    .sym_out     (sym_out),
    .sym_is_ctrl (sym_is_ctrl)
  );

  int checks = 0;
  int errors = 0;

  // reference state derived from the requirements
  int          rpos = 0;
  bit          rfill = 0;
  int          rleft = 0;
  bit          rpend = 0;
  logic [23:0] rpix = '0;
  logic [23:0] next_pix = 24'hA1B2C3;
  int          cyc = 0;
  int          unit_pix = 0;
  int          last_unit_pix = 0;
  int          stall_zeros = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // called just after a falling edge; one symbol slot
  task automatic step(bit v, bit le);
    bit         rdy_exp;
    logic [7:0] eb;
    bit         ec;
    string      tg;
    pix_valid = v;
    pix_data  = next_pix;
    line_end  = le;
    #1;
    rdy_exp = 0; eb = 8'h00; ec = 0; tg = "R4";
    if (rfill) begin
      if (rpos == TU - 1) begin eb = 8'hFC; ec = 1; tg = "R2"; end
      else tg = le ? "R10" : "R4";
    end else if (rleft > 0) begin
      eb = (rleft == 2) ? rpix[15:8] : rpix[7:0];
      rleft--;
      tg = le ? "R9" : "R3";
      if (le) rpend = 1;
    end else if (rpos == DS || le || rpend) begin
      eb = 8'h5C; ec = 1;
      tg = (rpos == DS) ? "R4" : (rpend ? "R9" : "R8");
      rfill = 1; rpend = 0;
    end else if (rpos <= DS - NS) begin
      rdy_exp = 1;
      if (v) begin
        rpix = next_pix; eb = next_pix[23:16]; rleft = 2; tg = "R3";
        unit_pix++;
        next_pix = next_pix * 24'd37 + 24'h1357B1;
      end else begin
        tg = "R7"; stall_zeros++;
      end
    end else begin
      tg = "R6";
    end
    check("R5", {31'd0, pix_ready}, {31'd0, rdy_exp}, "pix_ready");
    @(negedge clk);
    check(tg, {23'd0, sym_is_ctrl, sym_out}, {23'd0, ec, eb}, "ctrl+symbol");
    if (rpos == TU - 1) begin
      rpos = 0; rfill = 0; last_unit_pix = unit_pix; unit_pix = 0;
    end else begin
      rpos++;
    end
    cyc++;
  endtask

  task automatic align();
    while (rpos != 0) step(1'b1, 1'b0);
  endtask

  task automatic t_reset();
    pix_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, pix_ready}, 32'd0, "pix_ready in reset");
    check("R1", {23'd0, sym_is_ctrl, sym_out}, 32'd0, "symbol in reset");
    pix_valid = 1'b0;
    rst = 1'b0;
  endtask

  task automatic t_continuous();
    for (int i = 0; i < 3 * TU; i++) step(1'b1, 1'b0);
    check("R4", last_unit_pix, PPT, "pixels per full unit");
  endtask

  task automatic t_stall();
    int z0;
    align();
    z0 = stall_zeros;
    for (int i = 0; i < 2 * TU; i++) step((cyc % 5) != 2, 1'b0);
    check("R7", {31'd0, stall_zeros > z0}, 32'd1, "stall slots seen");
  endtask

  task automatic t_tail();
    align();
    for (int i = 0; i < TU; i++) step(!(rpos >= 29 && rpos <= 30), 1'b0);
    check("R6", last_unit_pix, PPT - 1, "pixels with late boundary stalled");
  endtask

  task automatic t_le_boundary();
    align();
    for (int i = 0; i < TU; i++) step(1'b1, rpos == 12);
    check("R8", last_unit_pix, 4, "pixels before early end");
    for (int i = 0; i < TU; i++) step(1'b1, 1'b0);
    check("R8", last_unit_pix, PPT, "next unit is fresh");
  endtask

  task automatic t_le_mid();
    align();
    for (int i = 0; i < TU; i++) step(1'b1, rpos == 13);
    check("R9", last_unit_pix, 5, "pixel finished before fill");
  endtask

  task automatic t_le_fill();
    align();
    for (int i = 0; i < TU; i++) step(1'b1, rpos == 36);
    check("R10", last_unit_pix, PPT, "line end in fill ignored");
    for (int i = 0; i < TU; i++) step(1'b1, 1'b0);
    check("R10", last_unit_pix, PPT, "following unit unaffected");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_continuous();
    t_stall();
    t_tail();
    t_le_boundary();
    t_le_mid();
    t_le_fill();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule